// File: doc/BRIEF.md
# Serial Program-Load Slave

This block lets an external programmer read and write an on-chip program memory over a four-wire serial link. The port is open only while the programmer holds the download-enable input high. Whenever that input is low, the serial clock and data inputs have no effect. Every transaction is a fixed 32-bit frame made of four bytes, each sent most significant bit first. The first byte is the opcode, the second and third bytes form an address, and the fourth byte carries write data in one direction and the reply in the other.

Programming works a page at a time. Load frames fill a page buffer. A commit frame copies that buffer into one page of the array, and the ready output stays low while the copy runs. Frames can also read a single byte, return fixed identification bytes, and set two sticky lock levels. The lower level blocks writes. The higher level also hides read data. The serial clock and data inputs are synchronised into the system clock domain. The serial clock must stay in each phase for at least six system clocks.

Top module: `prog_load_slave`

## Requirements
- R1: While `dl_active` is low, `ser_out` is 0 and frames sent on `ser_clk`/`ser_in` change no state. A load or commit sent this way leaves `wr_ready` at 1 and leaves the page buffer unchanged.
- R2: A frame is 32 bits, sampled on rising `ser_clk` edges, MSB first. The bytes are, in order: opcode, address high, address low, data. The address is the low ADDR_W bits of {address high, address low}.
- R3: The read opcode 0x20 returns the array byte at the address on `ser_out` during the fourth byte, MSB first. `ser_out` changes after falling edges, so each bit is valid before the rising edge that samples it.
- R4: The identify opcode 0x30 returns 0x1E when the address low byte is 0x30, 0x84 when it is 0x31, and 0x00 otherwise.
- R5: The load opcode 0x40 writes the data byte into the page-buffer slot given by the low PAGE_W bits of the address low byte. A slot not loaded since the last commit programs as 0xFF.
- R6: The commit opcode 0x4C copies the page buffer into page address[ADDR_W-1:PAGE_W]. `wr_ready` is low for exactly BUSY_CYCLES clocks after the frame completes. Load or commit frames that complete while `wr_ready` is low are ignored.
- R7: The lock opcode 0xAC uses data bit 0 to set the write lock, which refuses load and commit. It uses data bit 1 to set the full lock, which also refuses load and commit and makes reads return 0x00. Once set, a lock stays set until `rst`.
- R8: Any other opcode changes no state. Every opcode other than read and identify returns 0x00 during the fourth byte.
- R9: Dropping `dl_active` in the middle of a frame discards the partial frame. The next frame after `dl_active` rises again starts at bit 0.
- R10: Synchronous active-high `rst` clears both locks and the bit count, sets `wr_ready` to 1 and fills the page buffer with 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dl_active | input | 1 | Download enable; the serial port works only while high |
| ser_clk | input | 1 | Serial clock from the programmer, idle low |
| ser_in | input | 1 | Serial command and data input |
| ser_out | output | 1 | Serial reply output, driven during the fourth byte |
| wr_ready | output | 1 | High when idle, low during page programming |

## Verification
A page commit and a new frame can overlap: programming is still running when the next frame completes. The bench sets this up by sending a load frame right after a commit. The busy window is longer than one frame, so the load completes while `wr_ready` is low. The load targets a slot that the next page never loads. If the load was correctly refused, that byte reads back as 0xFF once the following page is programmed. The bench also counts the low cycles of `wr_ready` around that overlap and checks that the count equals BUSY_CYCLES.

// File: rtl/pld_pkg.sv
package pld_pkg;

    typedef enum logic [7:0] {
        OP_READ   = 8'h20,
        OP_IDENT  = 8'h30,
        OP_LOAD   = 8'h40,
        OP_COMMIT = 8'h4C,
        OP_LOCK   = 8'hAC
    } op_e;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] ahi;
        logic [7:0] alo;
        logic [7:0] dat;
    } frame_t;

    typedef struct packed {
        logic wr;
        logic all;
    } lock_t;

    localparam int FRAME_BITS = 32;
    localparam int HDR_BITS   = 24;

    function automatic logic [7:0] ident_byte(input logic [7:0] idx);
        case (idx)
            8'h30:   return 8'h1E;
            8'h31:   return 8'h84;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pld_shift.sv
module pld_shift
    import pld_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic        sclk_in,
    input  logic        sdat_in,
    input  logic [7:0]  tx_byte,
    output logic        hdr_done,
    output logic        frame_done,
    output logic [31:0] word,
    output logic        ser_out
);
    logic [1:0] ck_sync;
    logic       ck_prev;
    logic [1:0] d_sync;
    logic [4:0] cnt;
    logic [7:0] tx_sr;
    logic       rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sync <= '0;
            ck_prev <= 1'b0;
            d_sync  <= '0;
        end else begin
            ck_sync <= {ck_sync[0], sclk_in};
            ck_prev <= ck_sync[1];
            d_sync  <= {d_sync[0], sdat_in};
        end
    end

    assign rise = ck_sync[1] & ~ck_prev;
    assign fall = ~ck_sync[1] & ck_prev;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt        <= '0;
            word       <= '0;
            tx_sr      <= '0;
            hdr_done   <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            hdr_done   <= 1'b0;
            frame_done <= 1'b0;
            if (rise) begin
                word       <= {word[30:0], d_sync[1]};
                cnt        <= cnt + 5'd1;
                hdr_done   <= (cnt == 5'(HDR_BITS - 1));
                frame_done <= (cnt == 5'(FRAME_BITS - 1));
            end
            if (hdr_done)
                tx_sr <= tx_byte;
            else if (fall && cnt > 5'(HDR_BITS))
                tx_sr <= {tx_sr[6:0], 1'b0};
        end
    end

    assign ser_out = active && (cnt[4:3] == 2'b11) && tx_sr[7];

    assert_abort_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == 5'd0) && !frame_done && !hdr_done);

    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (cnt == 5'd0) && ($past(cnt) == 5'd31));

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!active && $past(!active)) |-> !ser_out);

endmodule

// File: rtl/pld_ctrl.sv
module pld_ctrl
    import pld_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hdr_done,
    input  logic                 frame_done,
    input  logic [31:0]          word,
    input  logic                 busy,
    input  logic [7:0]           rd_data,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           resp,
    output logic                 load_go,
    output logic [PAGE_W-1:0]    load_off,
    output logic [7:0]           load_data,
    output logic                 commit_go,
    output logic [ADDR_W-PAGE_W-1:0] commit_page
);
    frame_t      f;
    lock_t       locks;
    logic [7:0]  h_op;
    logic [15:0] h_addr;
    logic [15:0] f_addr;
    logic        writes_ok;

    assign f      = frame_t'(word);
    assign h_op   = word[23:16];
    assign h_addr = word[15:0];
    assign f_addr = {f.ahi, f.alo};

    assign rd_addr = h_addr[ADDR_W-1:0];

    always_comb begin
        case (h_op)
            OP_READ:  resp = locks.all ? 8'h00 : rd_data;
            OP_IDENT: resp = ident_byte(h_addr[7:0]);
            default:  resp = 8'h00;
        endcase
    end

    assign writes_ok   = !locks.wr && !locks.all && !busy;
    assign load_go     = frame_done && (f.op == OP_LOAD) && writes_ok;
    assign commit_go   = frame_done && (f.op == OP_COMMIT) && writes_ok;
    assign load_off    = f.alo[PAGE_W-1:0];
    assign load_data   = f.dat;
    assign commit_page = f_addr[ADDR_W-1:PAGE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            locks <= '0;
        end else if (frame_done && f.op == OP_LOCK) begin
            locks.wr  <= locks.wr  | f.dat[0];
            locks.all <= locks.all | f.dat[1];
        end
    end

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (locks.wr || locks.all) |=> (locks.wr || locks.all));

    assert_locked_refuse_R7: assert property (@(posedge clk) disable iff (rst)
        (locks.wr || locks.all) |-> !load_go && !commit_go);

    assert_busy_refuse_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !commit_go && !load_go);

endmodule

// File: rtl/pld_store.sv
module pld_store #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 7,
    parameter int BUSY_CYCLES = 15000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_go,
    input  logic [PAGE_W-1:0]        load_off,
    input  logic [7:0]               load_data,
    input  logic                     commit_go,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;
    localparam int BW    = $clog2(BUSY_CYCLES + 1);

    logic [7:0]              mem  [DEPTH];
    logic [7:0]              pbuf [PAGE];
    logic [BW-1:0]           cnt;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic                    copying;
    logic [PAGE_W-1:0]       slot;

    assign copying = busy && (cnt < BW'(PAGE));
    assign slot    = cnt[PAGE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'hFF;
        end else begin
            if (commit_go) begin
                busy   <= 1'b1;
                cnt    <= '0;
                page_q <= commit_page;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (cnt == BW'(BUSY_CYCLES - 1)) busy <= 1'b0;
                if (copying) pbuf[slot] <= 8'hFF;
            end
            if (load_go) pbuf[load_off] <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (copying) mem[{page_q, slot}] <= pbuf[slot];
    end

    assign rd_data = mem[rd_addr];

    assert_commit_busy_R6: assert property (@(posedge clk) disable iff (rst)
        commit_go |=> busy);

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt) == BW'(BUSY_CYCLES - 1));

    assert_load_idle_R5: assert property (@(posedge clk) disable iff (rst)
        load_go |-> !busy);

endmodule

// File: rtl/prog_load_slave.sv
module prog_load_slave #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 7,
    parameter int BUSY_CYCLES = 15000
) (
    input  logic clk,
    input  logic rst,
    input  logic dl_active,
    input  logic ser_clk,
    input  logic ser_in,
    output logic ser_out,
    output logic wr_ready
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic              hdr_done, frame_done, busy;
    logic [31:0]       word;
    logic [7:0]        resp, rd_data, load_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              load_go, commit_go;
    logic [PAGE_W-1:0] load_off;
    logic [PG_W-1:0]   commit_page;

    pld_shift u_shift (
        .clk(clk), .rst(rst), .active(dl_active),
        .sclk_in(ser_clk), .sdat_in(ser_in), .tx_byte(resp),
        .hdr_done(hdr_done), .frame_done(frame_done),
        .word(word), .ser_out(ser_out)
    );

    pld_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk(clk), .rst(rst), .hdr_done(hdr_done), .frame_done(frame_done),
        .word(word), .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
        .resp(resp), .load_go(load_go), .load_off(load_off),
        .load_data(load_data), .commit_go(commit_go), .commit_page(commit_page)
    );

    pld_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk(clk), .rst(rst), .load_go(load_go), .load_off(load_off),
        .load_data(load_data), .commit_go(commit_go), .commit_page(commit_page),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    assign wr_ready = !busy;

    assert_inactive_no_commit_R1: assert property (@(posedge clk) disable iff (rst)
        (!dl_active && $past(!dl_active)) |-> !commit_go && !load_go);

endmodule

// File: tb/prog_load_slave_tb.sv
module prog_load_slave_tb;
    localparam int AW   = 6;
    localparam int PW   = 3;
    localparam int BUSY = 800;
    localparam int H    = 6;

    logic clk = 0, rst = 1, dl_active = 0, ser_clk = 0, ser_in = 0;
    logic ser_out, wr_ready;
    int   checks = 0, errors = 0;
    int   low_total = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    prog_load_slave #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst(rst), .dl_active(dl_active), .ser_clk(ser_clk),
        .ser_in(ser_in), .ser_out(ser_out), .wr_ready(wr_ready)
    );

    always @(negedge clk) if (!wr_ready) low_total <= low_total + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] expv(input int a);
        if (a == 3 * 8 + 5) return 8'hFF;
        return pat(a);
    endfunction

    task automatic xfer(input logic [7:0] b1, b2, b3, b4, output logic [7:0] r);
        logic [31:0] w;
        w = {b1, b2, b3, b4};
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            ser_in = w[i];
            repeat (H) @(negedge clk);
            if (i < 8) r[i] = ser_out;
            ser_clk = 1;
            repeat (H) @(negedge clk);
            ser_clk = 0;
        end
        repeat (H) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000 && !wr_ready; i++) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int snap;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10 ready after reset", wr_ready, 1);
        chk("R1 out quiet after reset", ser_out, 0);
        dl_active = 1;
        repeat (4) @(negedge clk);

        xfer(8'h30, 8'h00, 8'h30, 8'h00, r); chk("R4 ident 30", r, 8'h1E);
        xfer(8'h30, 8'h00, 8'h31, 8'h00, r); chk("R4 ident 31", r, 8'h84);
        xfer(8'h30, 8'h00, 8'h32, 8'h00, r); chk("R4 ident other", r, 8'h00);

        for (int p = 0; p < 8; p++) begin
            for (int o = 0; o < 8; o++) begin
                if (!(p == 3 && o == 5)) begin
                    xfer(8'h40, 8'h00, 8'(o), pat(p * 8 + o), r);
                    if (p == 0 && o == 0) chk("R8 load reply zero", r, 8'h00);
                end
            end
            snap = low_total;
            xfer(8'h4C, 8'h00, 8'(p * 8), 8'h00, r);
            chk("R6 busy after commit", wr_ready, 0);
            if (p == 2) begin
                xfer(8'h40, 8'h00, 8'h05, 8'h99, r);
                chk("R6 still busy during overlap", wr_ready, 0);
            end
            wait_ready();
            repeat (2) @(negedge clk);
            chk("R6 busy length", low_total - snap, BUSY);
        end

        for (int a = 0; a < 64; a++) begin
            xfer(8'h20, 8'h00, 8'(a), 8'h00, r);
            chk($sformatf("R3 R5 read addr %0d", a), r, expv(a));
        end

        xfer(8'h20, 8'hA5, 8'h47, 8'h00, r);
        chk("R2 address truncation", r, expv(7));

        xfer(8'h41, 8'h00, 8'h00, 8'h12, r);
        chk("R8 unknown reply", r, 8'h00);
        chk("R8 unknown no busy", wr_ready, 1);
        xfer(8'h4C, 8'h00, 8'd56, 8'h00, r);
        wait_ready();
        xfer(8'h20, 8'h00, 8'd56, 8'h00, r);
        chk("R8 unknown left buffer", r, 8'hFF);
        xfer(8'h20, 8'h00, 8'd57, 8'h00, r);
        chk("R5 erased slot", r, 8'hFF);

        dl_active = 0;
        repeat (4) @(negedge clk);
        xfer(8'h20, 8'h00, 8'd9, 8'h00, r);
        chk("R1 no reply while inactive", r, 8'h00);
        xfer(8'h40, 8'h00, 8'h01, 8'h77, r);
        xfer(8'h4C, 8'h00, 8'd48, 8'h00, r);
        chk("R1 no commit while inactive", wr_ready, 1);
        dl_active = 1;
        repeat (4) @(negedge clk);
        xfer(8'h4C, 8'h00, 8'd48, 8'h00, r);
        wait_ready();
        xfer(8'h20, 8'h00, 8'd49, 8'h00, r);
        chk("R1 inactive load ignored", r, 8'hFF);

        for (int i = 0; i < 13; i++) begin
            ser_in = i[0];
            repeat (H) @(negedge clk);
            ser_clk = 1;
            repeat (H) @(negedge clk);
            ser_clk = 0;
        end
        dl_active = 0;
        repeat (4) @(negedge clk);
        dl_active = 1;
        repeat (4) @(negedge clk);
        xfer(8'h20, 8'h00, 8'd9, 8'h00, r);
        chk("R9 frame after abort", r, expv(9));

        xfer(8'hAC, 8'h00, 8'h00, 8'h01, r);
        xfer(8'h40, 8'h00, 8'h00, 8'h3C, r);
        xfer(8'h4C, 8'h00, 8'd8, 8'h00, r);
        chk("R7 write lock refuses commit", wr_ready, 1);
        xfer(8'h20, 8'h00, 8'd8, 8'h00, r);
        chk("R7 write lock keeps read", r, expv(8));
        xfer(8'hAC, 8'h00, 8'h00, 8'h02, r);
        xfer(8'h20, 8'h00, 8'd8, 8'h00, r);
        chk("R7 full lock hides read", r, 8'h00);

        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        chk("R10 ready after second reset", wr_ready, 1);
        xfer(8'h20, 8'h00, 8'd8, 8'h00, r);
        chk("R10 locks cleared", r, expv(8));
        xfer(8'h20, 8'h00, 8'd13, 8'h00, r);
        chk("R3 read after reset", r, expv(13));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule